// File: doc/BRIEF.md
# Soft Volume Ramp Controller

This block sequences the attenuation applied to each channel of a stereo digital-to-analog path. Each channel holds an 8-bit attenuation code in half-decibel units. Code 0 is full level and code 227 is the deepest audible setting. Anything above 227 is silence, and the block shows it as code 228. A register supplies the programmed code. The block works out the goal code for each channel from that code, a global active-low soft-mute pin and a mute bit per channel. It then moves the applied code toward the goal in one of two ways.

In ramp mode the applied code moves by one half-decibel step each time a shared step tick fires. The tick fires once every 4, 8, 16 or 32 sample strobes. In zero-crossing mode the whole change is made in one jump when that channel's signal crosses zero. If no crossing arrives, a timeout forces the change. Each channel also counts consecutive silent samples (all zeros or all ones). When that option is enabled, a long run of such samples mutes the channel, and the first sample that is not silent unmutes it at once. A pending flag per channel shows that the applied code has not yet reached its goal.

Top module: `volramp_ctrl`

## Requirements
- R1: After a synchronous reset, every channel reads applied code 0, with muted and pending both 0.
- R2: A programmed code above 227 gives goal code 228. Muted is 1 whenever the applied code is 228.
- R3: In ramp mode (zc_mode=0) the applied code changes only at a clock edge where lr_strobe is 1 and the step tick fires. It moves by exactly 1 toward the goal.
- R4: The step tick comes from one strobe counter shared by both channels. It fires on every Nth strobe, where rate_sel 0 gives N=8, 1 gives 4, 2 gives 16 and 3 gives 32.
- R5: If the goal changes in the middle of a ramp, stepping continues from the current applied code toward the new goal, with no jump.
- R6: In zero-crossing mode (zc_mode=1) the applied code jumps straight to the goal at a strobe edge where that channel's sample is zero, or where the sample's sign bit differs from the sign bit of the channel's previous strobed sample.
- R7: In zero-crossing mode, if no crossing occurs, the change is forced on the 512th strobe counted from the first strobe at which the change was pending.
- R8: Each channel detects crossings on its own samples only. A crossing on one channel never moves the other channel.
- R9: Pending goes to 1 at the clock edge after the goal first differs from the applied code. It returns to 0 at the edge where the applied code reaches the goal.
- R10: While soft_mute_n is 0, the goal of both channels is 228, reached by the selected method. When soft_mute_n returns to 1, the programmed code is restored by the same method.
- R11: ch_mute[c]=1 sets the goal of channel c alone to 228, by the selected method.
- R12: With zero_mute_en=1, muted goes to 1 at the edge of the 512th consecutive strobed sample that is all zeros or all ones. It returns to 0 at the edge of the first other sample. The applied code is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| att_target | input | NCH x CODE_W | Programmed attenuation code per channel |
| soft_mute_n | input | 1 | Global soft mute, active low |
| ch_mute | input | NCH | Per-channel mute request |
| zc_mode | input | 1 | 0 = stepped ramp, 1 = zero-crossing jump |
| rate_sel | input | 2 | Strobes per ramp step: 0→8, 1→4, 2→16, 3→32 |
| zero_mute_en | input | 1 | Enables muting on long runs of silent samples |
| lr_strobe | input | 1 | One-cycle pulse once per sample period |
| sample_in | input | NCH x SAMPLE_W | Signed sample per channel, read on lr_strobe |
| att_applied | output | NCH x CODE_W | Attenuation code currently applied |
| muted | output | NCH | Channel is silent |
| pending | output | NCH | Applied code differs from goal |

## Verification
The bench targets the zero-crossing timeout window. It places a channel with a constant-sign signal before and after the 512th strobe. A design with a wrong timeout count would jump too early, or would never jump. It retargets a ramp while the ramp is running, where a faulty design would jump or reset to the new goal. It also drives one channel with crossings and the other without, so any sharing of the crossing detectors shows up as the quiet channel moving. The silent-run mute is checked on both sides of its 512-sample threshold and on the first non-silent sample. A saturating or clearing error would mute late or fail to release.

// File: rtl/volramp_pkg.sv
package volramp_pkg;

  // Number of sample strobes per half-decibel ramp step, selected by rate_sel.
  function automatic int unsigned steps_per_tick(input logic [1:0] sel);
    case (sel)
      2'd1:    return 4;
      2'd2:    return 16;
      2'd3:    return 32;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/volramp_rate.sv
module volramp_rate #(
  parameter int unsigned MAX_STEPS = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe,
  input  logic [1:0] rate_sel,
  output logic       tick
);
  import volramp_pkg::*;

  localparam int unsigned CNT_W = $clog2(MAX_STEPS);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(steps_per_tick(rate_sel) - 1);
  assign tick  = strobe && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (strobe) begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/volramp_sig.sv
module volramp_sig #(
  parameter int unsigned SAMPLE_W = 20,
  parameter int unsigned RUN_LOG2 = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                strobe,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                zc,
  output logic                run_full_nxt
);
  localparam int unsigned RUN_W = RUN_LOG2 + 1;

  logic             sign_q;
  logic [RUN_W-1:0] run_q, run_d;
  logic             is_zero, is_quiet;

  assign is_zero  = (sample == '0);
  assign is_quiet = is_zero || (sample == '1);
  assign zc       = strobe && (is_zero || (sample[SAMPLE_W-1] != sign_q));

  always_comb begin
    run_d = run_q;
    if (strobe) begin
      if (!is_quiet)           run_d = '0;
      else if (!run_q[RUN_LOG2]) run_d = run_q + 1'b1;
    end
  end

  assign run_full_nxt = run_d[RUN_LOG2];

  always_ff @(posedge clk) begin
    if (rst) begin
      sign_q <= 1'b0;
      run_q  <= '0;
    end else begin
      run_q <= run_d;
      if (strobe) sign_q <= sample[SAMPLE_W-1];
    end
  end
endmodule

// File: rtl/volramp_chan.sv
module volramp_chan #(
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned MAX_ATT  = 227,
  parameter int unsigned TMO_LOG2 = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              tick,
  input  logic              zc,
  input  logic              zc_mode,
  input  logic [CODE_W-1:0] goal,
  input  logic              zero_mute_en,
  input  logic              run_full_nxt,
  output logic [CODE_W-1:0] att,
  output logic              muted,
  output logic              pending
);
  localparam logic [CODE_W-1:0] MUTE_C = CODE_W'(MAX_ATT + 1);

  logic [CODE_W-1:0]   att_q, att_d;
  logic [TMO_LOG2-1:0] tmo_q, tmo_d;
  logic                muted_q, pend_q;

  always_comb begin
    att_d = att_q;
    tmo_d = '0;
    if (att_q != goal) begin
      if (!zc_mode) begin
        if (tick) att_d = (goal > att_q) ? att_q + 1'b1 : att_q - 1'b1;
      end else if (strobe) begin
        if (zc || (tmo_q == '1)) att_d = goal;
        else                     tmo_d = tmo_q + 1'b1;
      end else begin
        tmo_d = tmo_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      att_q   <= '0;
      tmo_q   <= '0;
      muted_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      att_q   <= att_d;
      tmo_q   <= tmo_d;
      muted_q <= (att_d >= MUTE_C) || (zero_mute_en && run_full_nxt);
      pend_q  <= (att_d != goal);
    end
  end

  assign att     = att_q;
  assign muted   = muted_q;
  assign pending = pend_q;
endmodule

// File: rtl/volramp_ctrl.sv
module volramp_ctrl #(
  parameter int unsigned NCH       = 2,
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned MAX_ATT   = 227,
  parameter int unsigned SAMPLE_W  = 20,
  parameter int unsigned TMO_LOG2  = 9,
  parameter int unsigned RUN_LOG2  = 9,
  parameter int unsigned MAX_STEPS = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NCH-1:0][CODE_W-1:0]    att_target,
  input  logic                          soft_mute_n,
  input  logic [NCH-1:0]                ch_mute,
  input  logic                          zc_mode,
  input  logic [1:0]                    rate_sel,
  input  logic                          zero_mute_en,
  input  logic                          lr_strobe,
  input  logic [NCH-1:0][SAMPLE_W-1:0]  sample_in,
  output logic [NCH-1:0][CODE_W-1:0]    att_applied,
  output logic [NCH-1:0]                muted,
  output logic [NCH-1:0]                pending
);
  localparam logic [CODE_W-1:0] MUTE_C = CODE_W'(MAX_ATT + 1);

  logic tick;

  volramp_rate #(.MAX_STEPS(MAX_STEPS)) i_rate (
    .clk(clk), .rst(rst), .strobe(lr_strobe), .rate_sel(rate_sel), .tick(tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CODE_W-1:0] goal;
    logic              zc, run_full_nxt;

    always_comb begin
      if (!soft_mute_n || ch_mute[c])        goal = MUTE_C;
      else if (att_target[c] > MUTE_C - 1'b1) goal = MUTE_C;
      else                                   goal = att_target[c];
    end

    volramp_sig #(.SAMPLE_W(SAMPLE_W), .RUN_LOG2(RUN_LOG2)) i_sig (
      .clk(clk), .rst(rst), .strobe(lr_strobe), .sample(sample_in[c]),
      .zc(zc), .run_full_nxt(run_full_nxt)
    );

    volramp_chan #(.CODE_W(CODE_W), .MAX_ATT(MAX_ATT), .TMO_LOG2(TMO_LOG2)) i_chan (
      .clk(clk), .rst(rst), .strobe(lr_strobe), .tick(tick), .zc(zc),
      .zc_mode(zc_mode), .goal(goal), .zero_mute_en(zero_mute_en),
      .run_full_nxt(run_full_nxt), .att(att_applied[c]),
      .muted(muted[c]), .pending(pending[c])
    );
  end
endmodule

// File: rtl/volramp_ctrl_chk.sv
module volramp_ctrl_chk #(
  parameter int unsigned NCH     = 2,
  parameter int unsigned CODE_W  = 8,
  parameter int unsigned MAX_ATT = 227
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       zc_mode,
  input logic                       lr_strobe,
  input logic [NCH-1:0][CODE_W-1:0] att_applied,
  input logic [NCH-1:0]             muted,
  input logic [NCH-1:0]             pending
);
  localparam logic [CODE_W:0] MUTE_W = (CODE_W+1)'(MAX_ATT + 1);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic [CODE_W:0] a;
    assign a = {1'b0, att_applied[c]};

    // R2
    code_in_range_chk: assert property (@(posedge clk) disable iff (rst)
      a <= MUTE_W);

    // R2
    mute_code_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (a == MUTE_W) |-> muted[c]);

    // R3
    no_move_without_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      !lr_strobe |=> $stable(att_applied[c]));

    // R3
    single_step_ramp_chk: assert property (@(posedge clk) disable iff (rst)
      !zc_mode |=> (a == {1'b0, $past(att_applied[c])}) ||
                   (a == {1'b0, $past(att_applied[c])} + 1'b1) ||
                   (a + 1'b1 == {1'b0, $past(att_applied[c])}));

    // R6
    zc_jump_lands_chk: assert property (@(posedge clk) disable iff (rst)
      zc_mode |=> ($stable(att_applied[c]) || !pending[c]));
  end
endmodule

bind volramp_ctrl volramp_ctrl_chk #(.NCH(NCH), .CODE_W(CODE_W), .MAX_ATT(MAX_ATT)) i_volramp_chk (
  .clk(clk), .rst(rst), .zc_mode(zc_mode), .lr_strobe(lr_strobe),
  .att_applied(att_applied), .muted(muted), .pending(pending)
);

// File: tb/test_volramp_ctrl.sv
module test_volramp_ctrl;
  localparam int NCH = 2, CW = 8, SW = 20;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                     rst;
  logic [NCH-1:0][CW-1:0]   att_target;
  logic                     soft_mute_n;
  logic [NCH-1:0]           ch_mute;
  logic                     zc_mode;
  logic [1:0]               rate_sel;
  logic                     zero_mute_en;
  logic                     lr_strobe;
  logic [NCH-1:0][SW-1:0]   sample_in;
  logic [NCH-1:0][CW-1:0]   att_applied;
  logic [NCH-1:0]           muted, pending;

  volramp_ctrl i_volramp_ctrl (.*);

  int checks = 0, fails = 0, gap = 0, strobe_cnt = 0, kind = 0;
  bit done = 0;

  // reference model state
  int m_rc;
  int m_att[NCH], m_tc[NCH], m_zr[NCH];
  bit m_ps[NCH], m_mut[NCH], m_pend[NCH];

  function automatic int nsteps(input logic [1:0] s);
    return (s == 2'd1) ? 4 : (s == 2'd2) ? 16 : (s == 2'd3) ? 32 : 8;
  endfunction

  function automatic int goal_of(input int c);
    if (!soft_mute_n || ch_mute[c]) return 228;
    return (att_target[c] > 227) ? 228 : int'(att_target[c]);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_rc = 0;
      for (int c = 0; c < NCH; c++) begin
        m_att[c] = 0; m_tc[c] = 0; m_zr[c] = 0;
        m_ps[c] = 0; m_mut[c] = 0; m_pend[c] = 0;
      end
    end else begin
      bit tk;
      tk = lr_strobe && (m_rc >= nsteps(rate_sel) - 1);
      if (lr_strobe) m_rc = tk ? 0 : m_rc + 1;
      for (int c = 0; c < NCH; c++) begin
        int g, na, nt;
        bit quiet, zc;
        g = goal_of(c);
        quiet = (sample_in[c] == '0) || (sample_in[c] == '1);
        zc = lr_strobe && ((sample_in[c] == '0) || (sample_in[c][SW-1] != m_ps[c]));
        na = m_att[c]; nt = 0;
        if (na != g) begin
          if (!zc_mode) begin
            if (tk) na = (g > na) ? na + 1 : na - 1;
          end else if (lr_strobe) begin
            if (zc || m_tc[c] == 511) na = g;
            else nt = m_tc[c] + 1;
          end else nt = m_tc[c];
        end
        if (lr_strobe) begin
          m_ps[c] = sample_in[c][SW-1];
          m_zr[c] = quiet ? ((m_zr[c] >= 512) ? 512 : m_zr[c] + 1) : 0;
        end
        m_mut[c]  = (na >= 228) || (zero_mute_en && m_zr[c] >= 512);
        m_pend[c] = (na != g);
        m_att[c]  = na;
        m_tc[c]   = nt;
      end
    end
  end

  task automatic expect_val(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    for (int c = 0; c < NCH; c++) begin
      checks++;
      if (int'(att_applied[c]) != m_att[c] || muted[c] != m_mut[c] || pending[c] != m_pend[c]) begin
        fails++;
        $display("FAIL %s ch%0d att/muted/pending actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
                 req, c, att_applied[c], muted[c], pending[c], m_att[c], m_mut[c], m_pend[c]);
      end
    end
  endtask

  function automatic logic [SW-1:0] gen(input int c);
    case (kind)
      1: return SW'(32'h01000 + c);
      2: return ($urandom_range(0, 1) == 1) ? '1 : '0;
      3: return (c == 0) ? SW'(32'h00400) : SW'($urandom);
      default: return SW'($urandom);
    endcase
  endfunction

  task automatic run(input int ncyc, input string req);
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      compare(req);
      if (gap == 0) begin
        lr_strobe = 1'b1; gap = $urandom_range(1, 4); strobe_cnt++;
      end else begin
        lr_strobe = 1'b0; gap--;
      end
      for (int c = 0; c < NCH; c++) sample_in[c] = gen(c);
    end
  endtask

  task automatic run_strobes(input int n, input string req);
    int start;
    start = strobe_cnt;
    while (strobe_cnt - start < n) run(1, req);
    run(1, req);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; att_target = '0; soft_mute_n = 1'b1; ch_mute = '0; zc_mode = 1'b0;
    rate_sel = 2'd0; zero_mute_en = 1'b0; lr_strobe = 1'b0; sample_in = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      expect_val("R1", "reset att", int'(att_applied[c]), 0);
      expect_val("R1", "reset muted", int'(muted[c]), 0);
      expect_val("R1", "reset pending", int'(pending[c]), 0);
    end

    // R3 / R9: ramp 0 -> 20 and 6 at 8 strobes per step
    att_target[0] = 8'd20; att_target[1] = 8'd6;
    run(1, "R9");
    expect_val("R9", "pending after load", int'(pending[0]), 1);
    run(1400, "R3");
    expect_val("R3", "ramp end ch0", int'(att_applied[0]), 20);
    expect_val("R3", "ramp end ch1", int'(att_applied[1]), 6);
    expect_val("R9", "pending cleared", int'(pending[0]), 0);

    // R4: each rate setting
    rate_sel = 2'd1; att_target[0] = 8'd0;  run(400, "R4");
    expect_val("R4", "rate 4 end", int'(att_applied[0]), 0);
    rate_sel = 2'd2; att_target[0] = 8'd10; run(1000, "R4");
    rate_sel = 2'd3; att_target[1] = 8'd0;  run(1400, "R4");
    expect_val("R4", "rate 32 end", int'(att_applied[1]), 0);

    // R5: retarget mid ramp
    rate_sel = 2'd1; att_target[0] = 8'd100; run(200, "R5");
    att_target[0] = 8'd30; run(1500, "R5");
    expect_val("R5", "retarget end", int'(att_applied[0]), 30);

    // R2: out-of-range code
    att_target[0] = 8'd250; run(3600, "R2");
    expect_val("R2", "clamped code", int'(att_applied[0]), 228);
    expect_val("R2", "muted at 228", int'(muted[0]), 1);

    // R10: soft mute in ramp mode
    att_target[0] = 8'd50; att_target[1] = 8'd50;
    soft_mute_n = 1'b0; run(4000, "R10");
    expect_val("R10", "soft mute ch1", int'(att_applied[1]), 228);
    soft_mute_n = 1'b1; run(4000, "R10");
    expect_val("R10", "restore ch0", int'(att_applied[0]), 50);
    expect_val("R10", "restore ch1", int'(att_applied[1]), 50);

    // R6 / R8: zero-crossing mode, ch0 never crosses
    zc_mode = 1'b1; kind = 3; run(40, "R6");
    att_target[0] = 8'd90; att_target[1] = 8'd90;
    run(80, "R6");
    expect_val("R8", "ch1 jumped", int'(att_applied[1]), 90);
    expect_val("R8", "ch0 waits", int'(att_applied[0]), 50);

    // R7: timeout window
    run_strobes(480, "R7");
    expect_val("R7", "before timeout", int'(att_applied[0]), 50);
    run_strobes(30, "R7");
    expect_val("R7", "after timeout", int'(att_applied[0]), 90);

    // R11: per-channel mute, zero-crossing mode
    kind = 0; ch_mute[1] = 1'b1; run(150, "R11");
    expect_val("R11", "ch1 muted", int'(muted[1]), 1);
    expect_val("R11", "ch0 untouched", int'(att_applied[0]), 90);
    ch_mute[1] = 1'b0; run(150, "R11");
    expect_val("R11", "ch1 restored", int'(att_applied[1]), 90);

    // R10 in zero-crossing mode
    soft_mute_n = 1'b0; run(150, "R10");
    expect_val("R10", "zc soft mute", int'(att_applied[0]), 228);
    soft_mute_n = 1'b1; run(150, "R10");

    // R12: silent-run mute
    zc_mode = 1'b0; zero_mute_en = 1'b1; kind = 2;
    run_strobes(500, "R12");
    expect_val("R12", "below threshold", int'(muted[0]), 0);
    run_strobes(20, "R12");
    expect_val("R12", "run muted", int'(muted[0]), 1);
    expect_val("R12", "code kept", int'(att_applied[0]), 90);
    kind = 0; run_strobes(1, "R12");
    expect_val("R12", "released", int'(muted[1]), 0);

    // mixed random rounds
    for (int r = 0; r < 30; r++) begin
      att_target[0] = 8'($urandom_range(0, 255));
      att_target[1] = 8'($urandom_range(0, 240));
      rate_sel = 2'($urandom_range(0, 3));
      zc_mode = 1'($urandom_range(0, 1));
      ch_mute = 2'($urandom_range(0, 3));
      soft_mute_n = ($urandom_range(0, 4) != 0);
      zero_mute_en = 1'($urandom_range(0, 1));
      kind = $urandom_range(0, 3);
      run(1500, "R9");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule